// File: doc/BRIEF.md
# Dual-Clock Burst RAM with Two Wishbone Slave Ports

This block is a shared word memory that two Wishbone B3 slave ports can reach. Each port has its own clock and its own active-low reset, and the two clocks need not be related. A master on either port can run classic single cycles. It can also run incrementing bursts, whose addresses either step linearly or wrap inside an aligned block of 4, 8 or 16 words. Writes honour a byte-lane select, and a word written from one port can be read from the other.

Each port answers with a registered acknowledge. During an incrementing burst the port works out the next beat address on its own and fetches that word in advance, so that acknowledge can stay high on consecutive clocks. The master may drop strobe in the middle of a burst to stall it. It may end the burst with the end-of-burst cycle type or by dropping cycle. A port decodes only as many low word-address bits as the memory depth needs.

Top module: `wbx_dual_ram`

## Requirements
- R1: While a port's reset is asserted, and in the idle cycles after its release, its acknowledge is low, even when cycle and strobe are both high.
- R2: A classic cycle (cycle type 3'b000) is acknowledged in the clock after cycle and strobe are first seen high. Acknowledge then falls for at least one clock, so back-to-back classic accesses take two clocks each.
- R3: On a write, byte lane i (data bits 8i+7..8i) is updated only when select bit i is high. Writing A1FFFFFF with select 1000 over 00030004 leaves a1030004.
- R4: During an incrementing burst (cycle type 3'b010), acknowledge stays high on every clock in which strobe is high, once the first beat has been answered. With burst type 2'b00 (linear) each beat uses the whole previous word address plus one.
- R5: Burst types 2'b01, 2'b10 and 2'b11 wrap inside an aligned block of 4, 8 and 16 words. A 4-beat wrap that starts at word offset 2 visits offsets 2, 3, 0, 1.
- R6: A beat with cycle type 3'b111 (end of burst) is the last one: acknowledge falls after it. Issued alone, even with a wrap burst type, it behaves as one single access to the given address.
- R7: While cycle is high and strobe is low in a burst, no acknowledge is given. When strobe returns, the burst resumes at once with the data of the next predicted address.
- R8: Dropping cycle ends a burst. The next access starts a new address phase at the address then on the bus, with the usual one-clock wait.
- R9: Acknowledge is never high while cycle or strobe is low.
- R10: The two ports run from unrelated clocks and separate resets, and they share one storage. Data written on one port is read back on the other. Resetting one port does not disturb transfers on the other.
- R11: Word-address bits above log2(DEPTH) are ignored, so an address and the same address plus a multiple of DEPTH reach the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk_i | input | 1 | Port A clock |
| a_rst_ni | input | 1 | Port A asynchronous active-low reset |
| a_adr_i | input | 30 | Port A word address (byte address bits 31..2) |
| a_dat_i | input | 32 | Port A write data |
| a_sel_i | input | 4 | Port A byte-lane select |
| a_we_i | input | 1 | Port A write enable |
| a_cyc_i | input | 1 | Port A bus cycle |
| a_stb_i | input | 1 | Port A strobe |
| a_cti_i | input | 3 | Port A cycle type |
| a_bte_i | input | 2 | Port A burst type |
| a_dat_o | output | 32 | Port A read data |
| a_ack_o | output | 1 | Port A acknowledge |
| b_clk_i | input | 1 | Port B clock |
| b_rst_ni | input | 1 | Port B asynchronous active-low reset |
| b_adr_i | input | 30 | Port B word address (byte address bits 31..2) |
| b_dat_i | input | 32 | Port B write data |
| b_sel_i | input | 4 | Port B byte-lane select |
| b_we_i | input | 1 | Port B write enable |
| b_cyc_i | input | 1 | Port B bus cycle |
| b_stb_i | input | 1 | Port B strobe |
| b_cti_i | input | 3 | Port B cycle type |
| b_bte_i | input | 2 | Port B burst type |
| b_dat_o | output | 32 | Port B read data |
| b_ack_o | output | 1 | Port B acknowledge |

## Verification
A wrong predicted beat address appears at the ports on the very next acknowledged beat, as read data from the wrong word. This is why the wrap and linear bursts are checked against a bench memory model on every beat. An acknowledge register that is stuck or mis-timed shows within one clock: as an acknowledge in a request cycle, a stall cycle or an idle cycle, or as a missing acknowledge in a back-to-back beat. A fault in the shared two-bank storage, or in its lane masking, appears as corrupted data on the first read after the write, whichever port makes it.

// File: rtl/wbx_ram_pkg.sv
package wbx_ram_pkg;

  // cycle type codes
  localparam logic [2:0] CTI_CLASSIC = 3'b000;
  localparam logic [2:0] CTI_INCR    = 3'b010;
  localparam logic [2:0] CTI_LAST    = 3'b111;

  // burst address progression
  typedef enum logic [1:0] {
    BTE_LINEAR = 2'b00,
    BTE_WRAP4  = 2'b01,
    BTE_WRAP8  = 2'b10,
    BTE_WRAP16 = 2'b11
  } bte_e;

endpackage

// File: rtl/wbx_rst_sync.sv
module wbx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/wbx_addr_step.sv
module wbx_addr_step
  import wbx_ram_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic [AW-1:0] cur_i,
  input  bte_e          mode_i,
  output logic [AW-1:0] nxt_o
);

  logic [AW-1:0] inc;
  logic [AW-1:0] keep_mask;

  always_comb begin
    inc = cur_i + AW'(1);
    unique case (mode_i)
      BTE_WRAP4:  keep_mask = ~AW'(3);
      BTE_WRAP8:  keep_mask = ~AW'(7);
      BTE_WRAP16: keep_mask = ~AW'(15);
      default:    keep_mask = '0;
    endcase
    // bits under the mask stay, the rest take the incremented value
    nxt_o = (cur_i & keep_mask) | (inc & ~keep_mask);
  end

endmodule

// File: rtl/wbx_burst_port.sv
module wbx_burst_port
  import wbx_ram_pkg::*;
#(
  parameter int unsigned AW     = 8,
  parameter int unsigned ADR_W  = 30,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SEL_W  = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADR_W-1:0]  adr_i,
  input  logic [DATA_W-1:0] dat_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              we_i,
  input  logic              cyc_i,
  input  logic              stb_i,
  input  logic [2:0]        cti_i,
  input  logic [1:0]        bte_i,
  output logic              ack_o,
  output logic [AW-1:0]     mem_radr_o,
  output logic              mem_we_o,
  output logic [SEL_W-1:0]  mem_be_o,
  output logic [AW-1:0]     mem_wadr_o,
  output logic [DATA_W-1:0] mem_wdat_o
);

  logic          req;
  logic          beat_done;
  logic          go_on;
  logic          ack_q, ack_d;
  logic          cur_en;
  logic [AW-1:0] cur_q, cur_d;
  logic [AW-1:0] nxt;
  logic [AW-1:0] bus_adr;
  logic          addr_hi_unused;

  assign bus_adr        = adr_i[AW-1:0];
  assign addr_hi_unused = ^adr_i[ADR_W-1:AW];
  assign req            = cyc_i & stb_i;
  assign beat_done      = req & ack_q;
  assign go_on          = (cti_i == CTI_INCR);

  wbx_addr_step #(.AW(AW)) u_step (
    .cur_i  (cur_q),
    .mode_i (bte_e'(bte_i)),
    .nxt_o  (nxt)
  );

  // next state: acknowledge, beat address, memory read address
  always_comb begin
    ack_d      = ack_q;
    cur_d      = cur_q;
    cur_en     = 1'b0;
    mem_radr_o = bus_adr;
    if (!cyc_i) begin
      ack_d = 1'b0;
    end else if (beat_done) begin
      if (go_on) begin
        ack_d      = 1'b1;
        cur_d      = nxt;
        cur_en     = 1'b1;
        mem_radr_o = nxt;
      end else begin
        ack_d = 1'b0;
      end
    end else if (ack_q) begin
      // stalled burst: keep the prefetched word fresh
      mem_radr_o = cur_q;
    end else if (req) begin
      ack_d  = 1'b1;
      cur_d  = bus_adr;
      cur_en = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b0;
    else         ack_q <= ack_d;
  end

  always_ff @(posedge clk_i) begin
    if (cur_en) cur_q <= cur_d;
  end

  assign ack_o      = ack_q & req;
  assign mem_we_o   = beat_done & we_i;
  assign mem_be_o   = sel_i;
  assign mem_wadr_o = cur_q;
  assign mem_wdat_o = dat_i;

  // R2: a fresh request is answered on the next clock
  p_req_answered_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req && !ack_q) |=> ack_q);

  // R2: classic transfer ends after one acknowledge
  p_classic_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && cti_i == CTI_CLASSIC) |=> !ack_o);

  // R6: end-of-burst beat closes the transfer
  p_eob_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && cti_i == CTI_LAST) |=> !ack_o);

  // R4: linear burst steps the full word address by one
  p_linear_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && go_on && bte_e'(bte_i) == BTE_LINEAR) |=> (cur_q == $past(cur_q) + AW'(1)));

  // R5: wrapping bursts never leave their 16-word-aligned region
  p_wrap_block_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && go_on && bte_e'(bte_i) != BTE_LINEAR) |=> (cur_q[AW-1:4] == $past(cur_q[AW-1:4])));

  // R7: a strobe stall keeps the prefetched beat
  p_stall_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_i && !stb_i && ack_q) |=> (ack_q && $stable(cur_q)));

  // R8: dropping cycle clears the burst
  p_cyc_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_i |=> !ack_q);

endmodule

// File: rtl/wbx_xor_mem.sv
module wbx_xor_mem #(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SEL_W  = DATA_W / 8,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              a_clk_i,
  input  logic              a_we_i,
  input  logic [SEL_W-1:0]  a_be_i,
  input  logic [AW-1:0]     a_wadr_i,
  input  logic [DATA_W-1:0] a_wdat_i,
  input  logic [AW-1:0]     a_radr_i,
  output logic [DATA_W-1:0] a_rdat_o,
  input  logic              b_clk_i,
  input  logic              b_we_i,
  input  logic [SEL_W-1:0]  b_be_i,
  input  logic [AW-1:0]     b_wadr_i,
  input  logic [DATA_W-1:0] b_wdat_i,
  input  logic [AW-1:0]     b_radr_i,
  output logic [DATA_W-1:0] b_rdat_o
);

  // Each port owns one bank; a word's value is the XOR of both banks.
  logic [DATA_W-1:0] bank_a [DEPTH];
  logic [DATA_W-1:0] bank_b [DEPTH];
  logic [DATA_W-1:0] a_rdat_q;
  logic [DATA_W-1:0] b_rdat_q;

  always_ff @(posedge a_clk_i) begin
    for (int l = 0; l < int'(SEL_W); l++) begin
      if (a_we_i && a_be_i[l])
        bank_a[a_wadr_i][l*8 +: 8] <= a_wdat_i[l*8 +: 8] ^ bank_b[a_wadr_i][l*8 +: 8];
    end
    a_rdat_q <= bank_a[a_radr_i] ^ bank_b[a_radr_i];
  end

  always_ff @(posedge b_clk_i) begin
    for (int l = 0; l < int'(SEL_W); l++) begin
      if (b_we_i && b_be_i[l])
        bank_b[b_wadr_i][l*8 +: 8] <= b_wdat_i[l*8 +: 8] ^ bank_a[b_wadr_i][l*8 +: 8];
    end
    b_rdat_q <= bank_a[b_radr_i] ^ bank_b[b_radr_i];
  end

  assign a_rdat_o = a_rdat_q;
  assign b_rdat_o = b_rdat_q;

endmodule

// File: rtl/wbx_dual_ram.sv
module wbx_dual_ram #(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned ADR_W  = 30,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned SEL_W = DATA_W / 8
) (
  input  logic              a_clk_i,
  input  logic              a_rst_ni,
  input  logic [ADR_W-1:0]  a_adr_i,
  input  logic [DATA_W-1:0] a_dat_i,
  input  logic [SEL_W-1:0]  a_sel_i,
  input  logic              a_we_i,
  input  logic              a_cyc_i,
  input  logic              a_stb_i,
  input  logic [2:0]        a_cti_i,
  input  logic [1:0]        a_bte_i,
  output logic [DATA_W-1:0] a_dat_o,
  output logic              a_ack_o,
  input  logic              b_clk_i,
  input  logic              b_rst_ni,
  input  logic [ADR_W-1:0]  b_adr_i,
  input  logic [DATA_W-1:0] b_dat_i,
  input  logic [SEL_W-1:0]  b_sel_i,
  input  logic              b_we_i,
  input  logic              b_cyc_i,
  input  logic              b_stb_i,
  input  logic [2:0]        b_cti_i,
  input  logic [1:0]        b_bte_i,
  output logic [DATA_W-1:0] b_dat_o,
  output logic              b_ack_o
);

  localparam int unsigned AW     = $clog2(DEPTH);
  localparam int unsigned NPORTS = 2;

  logic [NPORTS-1:0]             clk_v, rstn_raw_v, rstn_v;
  logic [NPORTS-1:0]             we_v, cyc_v, stb_v, ack_v, mwe_v;
  logic [NPORTS-1:0][ADR_W-1:0]  adr_v;
  logic [NPORTS-1:0][DATA_W-1:0] wdat_v, mwdat_v;
  logic [NPORTS-1:0][SEL_W-1:0]  sel_v, mbe_v;
  logic [NPORTS-1:0][2:0]        cti_v;
  logic [NPORTS-1:0][1:0]        bte_v;
  logic [NPORTS-1:0][AW-1:0]     radr_v, wadr_v;

  assign clk_v      = {b_clk_i,  a_clk_i};
  assign rstn_raw_v = {b_rst_ni, a_rst_ni};
  assign we_v       = {b_we_i,   a_we_i};
  assign cyc_v      = {b_cyc_i,  a_cyc_i};
  assign stb_v      = {b_stb_i,  a_stb_i};
  assign adr_v      = {b_adr_i,  a_adr_i};
  assign wdat_v     = {b_dat_i,  a_dat_i};
  assign sel_v      = {b_sel_i,  a_sel_i};
  assign cti_v      = {b_cti_i,  a_cti_i};
  assign bte_v      = {b_bte_i,  a_bte_i};

  for (genvar g = 0; g < NPORTS; g++) begin : g_port
    wbx_rst_sync #(.STAGES(2)) u_rst (
      .clk_i  (clk_v[g]),
      .rst_ni (rstn_raw_v[g]),
      .rst_no (rstn_v[g])
    );

    wbx_burst_port #(
      .AW(AW), .ADR_W(ADR_W), .DATA_W(DATA_W), .SEL_W(SEL_W)
    ) u_port (
      .clk_i      (clk_v[g]),
      .rst_ni     (rstn_v[g]),
      .adr_i      (adr_v[g]),
      .dat_i      (wdat_v[g]),
      .sel_i      (sel_v[g]),
      .we_i       (we_v[g]),
      .cyc_i      (cyc_v[g]),
      .stb_i      (stb_v[g]),
      .cti_i      (cti_v[g]),
      .bte_i      (bte_v[g]),
      .ack_o      (ack_v[g]),
      .mem_radr_o (radr_v[g]),
      .mem_we_o   (mwe_v[g]),
      .mem_be_o   (mbe_v[g]),
      .mem_wadr_o (wadr_v[g]),
      .mem_wdat_o (mwdat_v[g])
    );
  end

  wbx_xor_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_mem (
    .a_clk_i  (a_clk_i),
    .a_we_i   (mwe_v[0]),
    .a_be_i   (mbe_v[0]),
    .a_wadr_i (wadr_v[0]),
    .a_wdat_i (mwdat_v[0]),
    .a_radr_i (radr_v[0]),
    .a_rdat_o (a_dat_o),
    .b_clk_i  (b_clk_i),
    .b_we_i   (mwe_v[1]),
    .b_be_i   (mbe_v[1]),
    .b_wadr_i (wadr_v[1]),
    .b_wdat_i (mwdat_v[1]),
    .b_radr_i (radr_v[1]),
    .b_rdat_o (b_dat_o)
  );

  assign a_ack_o = ack_v[0];
  assign b_ack_o = ack_v[1];

endmodule

// File: tb/wbx_dual_ram_bench.sv
`timescale 1ns/1ps
module wbx_dual_ram_bench;

  localparam int DEPTH = 256;
  localparam logic [2:0] CL = 3'b000, IN = 3'b010, LS = 3'b111;

  logic a_clk = 1'b0;
  logic b_clk = 1'b0;
  always #2.5 a_clk = ~a_clk;
  always #3.5 b_clk = ~b_clk;

  logic [1:0]        rst_n;
  logic [1:0][29:0]  adr;
  logic [1:0][31:0]  wdat;
  logic [1:0][31:0]  rdat;
  logic [1:0][3:0]   sel;
  logic [1:0]        we, cyc, stb, ack;
  logic [1:0][2:0]   cti;
  logic [1:0][1:0]   bte;

  logic [31:0] model [DEPTH];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  wbx_dual_ram #(.DEPTH(DEPTH)) u_wbx_dual_ram (
    .a_clk_i(a_clk), .a_rst_ni(rst_n[0]), .a_adr_i(adr[0]), .a_dat_i(wdat[0]),
    .a_sel_i(sel[0]), .a_we_i(we[0]), .a_cyc_i(cyc[0]), .a_stb_i(stb[0]),
    .a_cti_i(cti[0]), .a_bte_i(bte[0]), .a_dat_o(rdat[0]), .a_ack_o(ack[0]),
    .b_clk_i(b_clk), .b_rst_ni(rst_n[1]), .b_adr_i(adr[1]), .b_dat_i(wdat[1]),
    .b_sel_i(sel[1]), .b_we_i(we[1]), .b_cyc_i(cyc[1]), .b_stb_i(stb[1]),
    .b_cti_i(cti[1]), .b_bte_i(bte[1]), .b_dat_o(rdat[1]), .b_ack_o(ack[1])
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // drive point: just after the rising edge
  task automatic tick(input int p);
    if (p == 0) @(posedge a_clk); else @(posedge b_clk);
    #0.5;
  endtask

  // sample point: falling edge of the same cycle
  task automatic mid(input int p);
    if (p == 0) @(negedge a_clk); else @(negedge b_clk);
  endtask

  task automatic put(input int p, input logic c, input logic s, input logic w,
                     input logic [29:0] a, input logic [31:0] d, input logic [3:0] se,
                     input logic [2:0] ct, input logic [1:0] bt);
    cyc[p] = c; stb[p] = s; we[p] = w; adr[p] = a;
    wdat[p] = d; sel[p] = se; cti[p] = ct; bte[p] = bt;
  endtask

  task automatic model_write(input logic [29:0] a, input logic [31:0] d, input logic [3:0] se);
    for (int l = 0; l < 4; l++)
      if (se[l]) model[a % DEPTH][l*8 +: 8] = d[l*8 +: 8];
  endtask

  function automatic logic [29:0] beat_adr(input logic [29:0] a0, input logic [1:0] bt, input int k);
    logic [29:0] m;
    case (bt)
      2'b01:   m = 30'd3;
      2'b10:   m = 30'd7;
      2'b11:   m = 30'd15;
      default: m = '0;
    endcase
    if (bt == 2'b00) return a0 + 30'(k);
    return (a0 & ~m) | ((a0 + 30'(k)) & m);
  endfunction

  task automatic idle(input int p, input int n);
    for (int i = 0; i < n; i++) begin
      tick(p); put(p, 0, 0, 0, '0, '0, 4'hF, CL, 2'b00); mid(p);
      chk("R9 idle ack", 32'(ack[p]), 32'd0);
    end
  endtask

  task automatic single(input int p, input logic w, input logic [29:0] a, input logic [31:0] d,
                        input logic [3:0] se, input logic [2:0] ct, input logic [1:0] bt,
                        input string tag, output logic [31:0] got);
    tick(p); put(p, 1, 1, w, a, d, se, ct, bt); mid(p);
    chk({tag, " wait cycle"}, 32'(ack[p]), 32'd0);
    tick(p); mid(p);
    chk({tag, " ack"}, 32'(ack[p]), 32'd1);
    got = rdat[p];
    if (w) model_write(a, d, se);
    else   chk({tag, " data"}, rdat[p], model[a % DEPTH]);
  endtask

  task automatic burst(input int p, input logic w, input logic [29:0] a0, input logic [1:0] bt,
                       input int n, input logic [15:0] stall, input bit eob,
                       input logic [31:0] seed, input string tag);
    logic [29:0] a;
    logic [2:0]  ct;
    tick(p);
    put(p, 1, 1, w, a0, seed, 4'hF, (eob && n == 1) ? LS : IN, bt);
    mid(p);
    chk({tag, " first wait"}, 32'(ack[p]), 32'd0);
    for (int k = 0; k < n; k++) begin
      a  = beat_adr(a0, bt, k);
      ct = (eob && k == n - 1) ? LS : IN;
      if (k > 0 && stall[k]) begin
        tick(p); put(p, 1, 0, w, a, '0, 4'hF, ct, bt); mid(p);
        chk("R7 no ack while strobe low", 32'(ack[p]), 32'd0);
      end
      tick(p); put(p, 1, 1, w, a, seed + 32'h00020002 * k, 4'hF, ct, bt); mid(p);
      chk({tag, " beat ack"}, 32'(ack[p]), 32'd1);
      if (w) model_write(a, seed + 32'h00020002 * k, 4'hF);
      else   chk({tag, " beat data"}, rdat[p], model[a % DEPTH]);
    end
    tick(p); put(p, 0, 0, 0, '0, '0, 4'hF, CL, 2'b00); mid(p);
    chk("R8 R6 ack low after burst", 32'(ack[p]), 32'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge a_clk);
    errors++;
    $display("FAIL watchdog expired, got hang expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] got;
    rst_n = 2'b00;
    put(0, 0, 0, 0, '0, '0, 4'hF, CL, 2'b00);
    put(1, 0, 0, 0, '0, '0, 4'hF, CL, 2'b00);

    // R1: request during reset gets no acknowledge
    tick(0); put(0, 1, 1, 0, 30'h40, '0, 4'hF, CL, 2'b00); mid(0);
    chk("R1 ack in reset A", 32'(ack[0]), 32'd0);
    tick(0); mid(0);
    chk("R1 ack in reset A held", 32'(ack[0]), 32'd0);
    put(0, 0, 0, 0, '0, '0, 4'hF, CL, 2'b00);
    tick(0); rst_n = 2'b11;
    repeat (4) tick(1);
    mid(0); chk("R1 ack after release A", 32'(ack[0]), 32'd0);
    mid(1); chk("R1 ack after release B", 32'(ack[1]), 32'd0);
    idle(0, 2);

    // R2: classic write then back-to-back classic read
    single(0, 1, 30'h40, 32'h12345678, 4'hF, CL, 2'b00, "R2 write", got);
    single(0, 0, 30'h40, '0, 4'hF, CL, 2'b00, "R2 read", got);
    chk("R2 read value", got, 32'h12345678);

    // R6: lone end-of-burst with 4-beat wrap type acts as single access
    single(0, 1, 30'h42, 32'h87654321, 4'hF, LS, 2'b01, "R6 lone eob write", got);
    single(0, 0, 30'h42, '0, 4'hF, CL, 2'b00, "R6 readback", got);
    chk("R6 value", got, 32'h87654321);
    idle(0, 1);

    // R4: linear write burst, then R3 byte-lane write
    burst(0, 1, 30'h40, 2'b00, 4, 16'h0, 1'b1, 32'h00010002, "R4 linear write");
    single(0, 1, 30'h41, 32'hA1FFFFFF, 4'b1000, CL, 2'b00, "R3 lane write", got);
    single(0, 0, 30'h41, '0, 4'hF, CL, 2'b00, "R3 lane read", got);
    chk("R3 merged lanes", got, 32'ha1030004);

    // R5: 4-beat wrap from offset 2 (order 2,3,0,1)
    burst(0, 0, 30'h42, 2'b01, 4, 16'h0, 1'b1, '0, "R5 wrap4 read");
    // R7: stalls inside a wrap read burst
    burst(0, 0, 30'h40, 2'b01, 4, 16'b1010, 1'b1, '0, "R7 stalled wrap4");
    burst(0, 0, 30'h43, 2'b01, 4, 16'b0110, 1'b1, '0, "R7 stalled wrap4 b");

    // R8: linear burst ended by dropping cycle, then a new address phase
    burst(0, 1, 30'h80, 2'b00, 8, 16'h0, 1'b0, 32'h11110000, "R4 linear write 8");
    burst(0, 0, 30'h80, 2'b00, 8, 16'h0, 1'b0, '0, "R8 linear read no eob");
    single(0, 0, 30'h85, '0, 4'hF, CL, 2'b00, "R8 new phase", got);

    // R5: 8 and 16 beat wraps
    burst(0, 1, 30'hA0, 2'b00, 16, 16'h0, 1'b1, 32'h20000000, "R4 linear write 16");
    burst(0, 0, 30'hA5, 2'b10, 8, 16'h0, 1'b1, '0, "R5 wrap8 read");
    burst(0, 0, 30'hAD, 2'b11, 16, 16'h0, 1'b1, '0, "R5 wrap16 read");
    burst(0, 1, 30'hB6, 2'b01, 4, 16'b0100, 1'b1, 32'h30000000, "R5 wrap4 write");
    burst(0, 0, 30'hB4, 2'b00, 4, 16'h0, 1'b1, '0, "R5 wrap4 write readback");

    // R11: high address bits ignored
    single(0, 0, 30'h40 + 30'(DEPTH), '0, 4'hF, CL, 2'b00, "R11 alias read", got);
    chk("R11 alias value", got, 32'h00010002);
    single(0, 0, 30'h2000_0041, '0, 4'hF, CL, 2'b00, "R11 alias high", got);
    chk("R11 alias high value", got, 32'ha1030004);
    idle(0, 1);

    // R10: cross-port visibility
    idle(1, 1);
    single(1, 0, 30'h41, '0, 4'hF, CL, 2'b00, "R10 B reads A data", got);
    chk("R10 B value", got, 32'ha1030004);
    burst(1, 1, 30'h50, 2'b00, 4, 16'b0010, 1'b1, 32'h50500000, "R10 B write burst");
    idle(1, 1);
    burst(0, 0, 30'h50, 2'b01, 4, 16'h0, 1'b1, '0, "R10 A reads B data");

    // R10: both ports busy at once, then B reset alone while A works
    fork
      begin
        burst(0, 0, 30'hA3, 2'b11, 16, 16'b0001_0000_1000_0000, 1'b1, '0, "R10 A concurrent");
        burst(0, 0, 30'h82, 2'b10, 8, 16'h0, 1'b1, '0, "R10 A during B reset");
      end
      begin
        burst(1, 1, 30'hC0, 2'b00, 8, 16'h0, 1'b1, 32'hC0C00000, "R10 B concurrent");
        tick(1); rst_n[1] = 1'b0; put(1, 1, 1, 0, 30'hC3, '0, 4'hF, CL, 2'b00);
        mid(1); chk("R1 B ack in own reset", 32'(ack[1]), 32'd0);
        tick(1); mid(1); chk("R1 B ack in own reset held", 32'(ack[1]), 32'd0);
        put(1, 0, 0, 0, '0, '0, 4'hF, CL, 2'b00);
        tick(1); rst_n[1] = 1'b1;
        idle(1, 4);
        single(1, 0, 30'hC3, '0, 4'hF, CL, 2'b00, "R10 B after reset", got);
      end
    join
    idle(0, 1);
    burst(0, 0, 30'hC0, 2'b00, 8, 16'h0, 1'b1, '0, "R10 A reads B concurrent data");
    idle(0, 2);
    finish_run();
  end

endmodule